// File: doc/BRIEF.md
# I/Q Serial Sample Output Port

This block sends receive-path baseband samples to a signal processor over three wires: a bit clock, a frame strobe and one data line. A single counter, running on the master clock, produces all three waveforms. The bit clock runs at one quarter of the master clock. Every 64 master cycles, one 16-bit word is framed onto the line. Each word holds a 15-bit channel sample, MSB first, and ends with one tag bit that names the channel. Words alternate between I and Q, so each channel gets a fresh word every 128 master cycles.

The sample source presents I and Q in parallel with a strobe. The port keeps the most recent strobed pair and copies it into its output registers only when an I word is about to start. This means a Q word always belongs to the same sample instant as the I word sent just before it. When the enable input is low, the counter is held at its start point and all three outputs are released. Each line is modelled as a value plus an output enable, so a pad ring can build the tri-state driver.

Top module: `iq_serial_port`

## Requirements
- R1: While rst_ni is low, all three output enables are 0 and all three data values are 0.
- R2: While the port is active, sclk_o repeats with a period of 4 master cycles: high for 2 cycles, then low for 2 cycles. The first high cycle is the first active cycle.
- R3: frame_o is high for the 4 master cycles of the first bit of every word, which is once per 64 master cycles, and it rises in the same cycle as sclk_o.
- R4: Bit positions 0 to 14 of a word carry the 15-bit sample, MSB first. Each bit occupies one bit-clock period.
- R5: Bit position 15, the last bit of a word, is the channel tag: 0 for an I word, 1 for a Q word. Words alternate I, Q, I, Q, and the first word after enabling is an I word.
- R6: data_o changes only in a cycle in which sclk_o rises, except when the port is being disabled.
- R7: An output enable goes high one cycle after en_i is sampled high and low one cycle after en_i is sampled low. While disabled, sclk_o, frame_o and data_o are 0.
- R8: A strobe on sample_valid_i records both inputs. The recorded pair is copied to the output only at the start of an I word, and the most recent strobe wins. A strobe in the last cycle before that start is included. A strobe during an I or Q word does not change either word of the pair in progress.
- R9: Disabling the port restarts the timing. After re-enabling, the first word is an I word that carries the pair recorded most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable |
| sample_valid_i | input | 1 | Strobe for i_sample_i and q_sample_i |
| i_sample_i | input | 15 | I channel sample |
| q_sample_i | input | 15 | Q channel sample |
| sclk_o | output | 1 | Bit clock value |
| sclk_oe_o | output | 1 | Bit clock output enable |
| frame_o | output | 1 | Frame strobe value |
| frame_oe_o | output | 1 | Frame strobe output enable |
| data_o | output | 1 | Serial data value |
| data_oe_o | output | 1 | Serial data output enable |

## Verification
The assertions assume that en_i and the sample strobe are synchronous to the master clock. They also assume that en_i is held low during reset, so the enable-latency checks begin from a known released state. The stimulus drives every input on the falling edge. It keeps en_i low until reset has been released, and it places strobes both before an I word and in the middle of words. It also drops the enable part-way through a frame, to cover the restart path.

// File: rtl/iqsp_pkg.sv
package iqsp_pkg;
  typedef struct packed {
    logic sclk;
    logic frame;
    logic data;
  } ser_lines_t;
endpackage

// File: rtl/iqsp_timing.sv
module iqsp_timing #(
  parameter int BCLK_DIV = 4,
  parameter int WORD_W   = 16,
  localparam int FRAME_LEN = BCLK_DIV * WORD_W,
  localparam int PAIR_LEN  = 2 * FRAME_LEN,
  localparam int CNT_W     = $clog2(PAIR_LEN),
  localparam int DIV_W     = $clog2(BCLK_DIV),
  localparam int BIT_W     = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  output logic             sclk_o,
  output logic             frame_o,
  output logic [BIT_W-1:0] bit_idx_o,
  output logic             q_word_o,
  output logic             reload_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign phase     = cnt_q[DIV_W-1:0];
  assign bit_idx_o = cnt_q[DIV_W +: BIT_W];
  assign q_word_o  = cnt_q[CNT_W-1];
  assign sclk_o    = run_i && (phase < DIV_W'(BCLK_DIV / 2));
  assign frame_o   = run_i && (bit_idx_o == '0);
  // copy new pair in just before the I word begins
  assign reload_o  = !run_i || (cnt_q == CNT_W'(PAIR_LEN - 1));

  assert_sclk_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    $rose(sclk_o) |=> sclk_o);
  assert_sclk_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    $fell(sclk_o) |=> !sclk_o);
  assert_frame_align_R3: assert property (@(posedge clk_i) disable iff (!rst_ni || !run_i)
    $rose(frame_o) |-> $rose(sclk_o));
  assert_restart_i_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (!q_word_o && frame_o));
endmodule

// File: rtl/iqsp_word.sv
module iqsp_word #(
  parameter int SAMPLE_W = 15,
  localparam int WORD_W  = SAMPLE_W + 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                reload_i,
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] i_i,
  input  logic [SAMPLE_W-1:0] q_i,
  input  logic [BIT_W-1:0]    bit_idx_i,
  input  logic                q_word_i,
  output logic                data_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [SAMPLE_W-1:0] hold_i_q, hold_q_q, act_i_q, act_q_q;
  logic [SAMPLE_W-1:0] nxt_i, nxt_q;
  logic [WORD_W-1:0]   word;

  assign nxt_i = valid_i ? i_i : hold_i_q;
  assign nxt_q = valid_i ? q_i : hold_q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_i_q <= '0;
      hold_q_q <= '0;
      act_i_q  <= '0;
      act_q_q  <= '0;
    end else begin
      hold_i_q <= nxt_i;
      hold_q_q <= nxt_q;
      if (reload_i) begin
        act_i_q <= nxt_i;
        act_q_q <= nxt_q;
      end
    end
  end

  assign word   = q_word_i ? {act_q_q, 1'b1} : {act_i_q, 1'b0};
  assign data_o = run_i && word[LAST_BIT - bit_idx_i];

  assert_pair_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(reload_i) |-> ($stable(act_i_q) && $stable(act_q_q)));
  assert_tag_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && bit_idx_i == LAST_BIT) |-> (data_o == q_word_i));
endmodule

// File: rtl/iq_serial_port.sv
module iq_serial_port #(
  parameter int SAMPLE_W = 15,
  parameter int BCLK_DIV = 4,
  localparam int WORD_W  = SAMPLE_W + 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                sample_valid_i,
  input  logic [SAMPLE_W-1:0] i_sample_i,
  input  logic [SAMPLE_W-1:0] q_sample_i,
  output logic                sclk_o,
  output logic                sclk_oe_o,
  output logic                frame_o,
  output logic                frame_oe_o,
  output logic                data_o,
  output logic                data_oe_o
);
  import iqsp_pkg::*;

  logic             run_q;
  logic [BIT_W-1:0] bit_idx;
  logic             q_word, reload;
  ser_lines_t       lines;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  iqsp_timing #(.BCLK_DIV(BCLK_DIV), .WORD_W(WORD_W)) i_timing (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .sclk_o    (lines.sclk),
    .frame_o   (lines.frame),
    .bit_idx_o (bit_idx),
    .q_word_o  (q_word),
    .reload_o  (reload)
  );

  iqsp_word #(.SAMPLE_W(SAMPLE_W)) i_word (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_q),
    .reload_i  (reload),
    .valid_i   (sample_valid_i),
    .i_i       (i_sample_i),
    .q_i       (q_sample_i),
    .bit_idx_i (bit_idx),
    .q_word_i  (q_word),
    .data_o    (lines.data)
  );

  assign sclk_o     = lines.sclk;
  assign frame_o    = lines.frame;
  assign data_o     = lines.data;
  assign sclk_oe_o  = run_q;
  assign frame_oe_o = run_q;
  assign data_oe_o  = run_q;

  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (!sclk_oe_o && !frame_oe_o && !data_oe_o &&
                                    !sclk_o && !frame_o && !data_o);
    end
  end

  assert_oe_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (sclk_oe_o && frame_oe_o && data_oe_o));
  assert_oe_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !(sclk_oe_o || frame_oe_o || data_oe_o || sclk_o || frame_o || data_o));
  assert_data_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni || !data_oe_o)
    !$stable(data_o) |-> $rose(sclk_o));
endmodule

// File: tb/test_iq_serial_port.sv
`timescale 1ns/1ps
module test_iq_serial_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, valid = 1'b0;
  logic [14:0] i_in = '0, q_in = '0;
  logic sclk, sclk_oe, frame, frame_oe, data, data_oe;

  always #2.5 clk = ~clk;

  iq_serial_port i_iq_serial_port (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sample_valid_i(valid),
    .i_sample_i(i_in), .q_sample_i(q_in),
    .sclk_o(sclk), .sclk_oe_o(sclk_oe), .frame_o(frame), .frame_oe_o(frame_oe),
    .data_o(data), .data_oe_o(data_oe));

  int errors = 0, checks = 0;
  string cur_req = "R1";

  // behavioural reference
  bit m_run = 0;
  int m_pos = 0;
  logic [14:0] m_i = '0, m_q = '0, m_hi = '0, m_hq = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_pos = 0; m_i = '0; m_q = '0; m_hi = '0; m_hq = '0;
    end else begin
      logic [14:0] ni, nq;
      ni = valid ? i_in : m_hi;
      nq = valid ? q_in : m_hq;
      if (!m_run || m_pos == 127) begin m_i = ni; m_q = nq; end
      m_pos = m_run ? (m_pos + 1) % 128 : 0;
      m_hi = ni; m_hq = nq;
      m_run = en;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  logic prev_data = 0, prev_sclk = 0;

  always @(negedge clk) begin
    logic [15:0] w;
    int bi;
    logic e_sclk, e_frame, e_data;
    w  = (m_pos >= 64) ? {m_q, 1'b1} : {m_i, 1'b0};
    bi = (m_pos % 64) / 4;
    e_sclk  = m_run && ((m_pos % 4) < 2);
    e_frame = m_run && ((m_pos % 64) < 4);
    e_data  = m_run && w[15 - bi];
    if (!rst_n) begin
      chk("R1", sclk_oe | frame_oe | data_oe, 1'b0);
      chk("R1", sclk | frame | data, 1'b0);
    end else begin
      chk("R7", sclk_oe, m_run); chk("R7", frame_oe, m_run); chk("R7", data_oe, m_run);
      chk("R2", sclk, e_sclk);
      chk("R3", frame, e_frame);
      if (cur_req != "") chk(cur_req, data, e_data);
      else if (bi == 15) chk("R5", data, e_data);
      else chk("R4", data, e_data);
      if (data_oe && data !== prev_data) chk("R6", sclk && !prev_sclk, 1'b1);
    end
    prev_data = data; prev_sclk = sclk;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [14:0] a, input logic [14:0] b);
    @(negedge clk); valid = 1; i_in = a; q_in = b;
    @(negedge clk); valid = 0;
  endtask

  initial begin
    fork
      begin
        cyc(3);
        rst_n = 1;
        cur_req = "";
        cyc(2);
        strobe(15'h7FFF, 15'h0000);
        en = 1;
        cyc(200);
        for (int k = 0; k < 8; k++) begin
          strobe(15'h5555 ^ 15'(k * 977), 15'h2AAA + 15'(k * 311));
          cyc(120 + 17 * k);
        end
        strobe(15'h4001, 15'h0180);
        cyc(300);
        cur_req = "R8";
        cyc(10); strobe(15'h1234, 15'h4321);
        cyc(70); strobe(15'h0F0F, 15'h70F0);
        cyc(5);  strobe(15'h6666, 15'h1999);
        cyc(400);
        cur_req = "R9";
        cyc(37); en = 0;
        cyc(20); strobe(15'h3C3C, 15'h43C3);
        cyc(3); en = 1;
        cyc(150); en = 0;
        cyc(1); en = 1;
        cyc(300);
        cur_req = "R5";
        strobe(15'h0000, 15'h7FFF);
        cyc(300);
      end
      begin
        cyc(100000);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule